// File: doc/BRIEF.md
# Modem Line Control and Status Unit with Loopback

This block holds the modem control state of one serial channel and reports the modem status back to the host. A five-bit control register drives the four active-low modem outputs and selects an internal loopback mode. The four active-low modem inputs pass through a two-flop synchronizer. They are then presented as current levels in the upper half of an eight-bit status word. Change flags in the lower half latch every transition until the host reads the word.

In loopback the block rewires the channel for self-test. Transmit serial data from the shift register is returned to the receive path. The external transmit pin sits at the idle mark level and the modem outputs stay inactive. The status levels are taken from the control bits instead of the pins. The block also produces a transmit-hold signal that tracks the clear-to-send status only between characters, and a status-change request for the interrupt logic.

Top module: `modem_ctl_stat`

## Requirements
- R1: After a synchronous active-low reset held for at least three clocks, the control register is zero, all four modem outputs are high, status bits 3..0 are zero, status bits 7..4 equal the inverted modem inputs, and msr_irq_o is low.
- R2: Outside loopback, dtr_n_o, rts_n_o, op1_n_o and op2_n_o are the complements of control bits 0, 1, 2 and 3 respectively, one clock after a write with mcr_wr.
- R3: Outside loopback, status bits 4, 5, 6 and 7 are the inverted levels of cts_n_i, dsr_n_i, ri_n_i and dcd_n_i. A change on an input reaches them on the second rising edge after it.
- R4: Status bits 0, 1 and 3 set when the clear-to-send, data-set-ready or carrier status changes level. Bit 2 sets only when the ring status falls from 1 to 0.
- R5: Each change flag stays set until a cycle with msr_rd high. msr_rdata shows the flags before clearing. A change that sets a flag in the read cycle itself is kept.
- R6: msr_irq_o is high exactly when any of status bits 3..0 is set.
- R7: With control bit 4 set (loopback), the status levels come from the control register: CTS from bit 1, DSR from bit 0, RI from bit 2, carrier from bit 3. The external modem inputs have no effect on the status word.
- R8: In loopback, rx_ser_o equals tx_ser_i, tx_pin_o is high, and all four modem outputs are high. Outside loopback, tx_pin_o equals tx_ser_i and rx_ser_o equals rx_pin_i.
- R9: tx_hold_o loads the inverted clear-to-send status on each rising edge where tx_idle_i is high. It holds its value while tx_idle_i is low, so a deasserted clear-to-send pauses the transmitter only after the current character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mcr_wr | input | 1 | Write strobe for the control register |
| mcr_wdata | input | 5 | Control value: 0 DTR, 1 RTS, 2 OP1, 3 OP2, 4 loopback |
| mcr_q | output | 5 | Current control register |
| msr_rd | input | 1 | Status read strobe, clears change flags |
| msr_rdata | output | 8 | Status word: 3..0 change flags, 7..4 levels |
| cts_n_i | input | 1 | Clear-to-send input, active low |
| dsr_n_i | input | 1 | Data-set-ready input, active low |
| ri_n_i | input | 1 | Ring indicator input, active low |
| dcd_n_i | input | 1 | Carrier detect input, active low |
| dtr_n_o | output | 1 | Data-terminal-ready output, active low |
| rts_n_o | output | 1 | Request-to-send output, active low |
| op1_n_o | output | 1 | User output 1, active low |
| op2_n_o | output | 1 | User output 2, active low |
| tx_ser_i | input | 1 | Serial data from the transmit shift register |
| tx_pin_o | output | 1 | Serial data to the external transmit pin |
| rx_pin_i | input | 1 | Serial data from the external receive pin |
| rx_ser_o | output | 1 | Serial data to the receive shift register |
| tx_idle_i | input | 1 | Transmitter is between characters |
| tx_hold_o | output | 1 | Hold the transmitter before the next character |
| msr_irq_o | output | 1 | Modem status change request |

## Verification
A vector table pairs control values with modem input patterns. Complementary and mixed bit patterns show that every output and status bit maps to its own pin and not to a neighbour. Loopback rows with contrasting external inputs show that the status word follows the control bits and not the pins. The serial path is checked with opposite levels on the two serial inputs to separate the echo from the pass-through. Directed tests then toggle single inputs to tell rising from falling ring edges. They align a change with the read cycle to show the flag survives the clear, and hold the transmitter busy to show clear-to-send takes effect only between characters.

// File: rtl/mcs_pkg.sv
// Shared widths and bit positions for the modem control/status unit.
// Assumes one channel; bit positions are the software-visible layout.
package mcs_pkg;
    localparam int MODEM_W  = 4;
    localparam int MCR_W    = 5;
    localparam int MCR_DTR  = 0;
    localparam int MCR_RTS  = 1;
    localparam int MCR_OP1  = 2;
    localparam int MCR_OP2  = 3;
    localparam int MCR_LOOP = 4;
    localparam int ST_CTS   = 0;
    localparam int ST_DSR   = 1;
    localparam int ST_RI    = 2;
    localparam int ST_DCD   = 3;
endpackage

// File: rtl/mcs_sync.sv
// Multi-stage synchronizer for asynchronous level inputs.
// Assumes inputs are slow levels; flops are not reset, so they keep sampling
// during reset and the status is valid as soon as reset ends.
module mcs_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture the raw asynchronous inputs
                always_ff @(posedge clk) stg[0] <= d_i;
            end else begin : g_next
                // pass the sample one stage further
                always_ff @(posedge clk) stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mcs_route.sv
// Loopback routing: selects status sources, drives modem and serial outputs.
// Assumes status vector order {dcd, ri, dsr, cts}, active-high.
module mcs_route
    import mcs_pkg::*;
(
    input  logic [MCR_W-1:0]   mcr_i,
    input  logic [MODEM_W-1:0] sync_n_i,
    input  logic               tx_ser_i,
    input  logic               rx_pin_i,
    output logic [MODEM_W-1:0] stat_o,
    output logic [MODEM_W-1:0] mout_n_o,
    output logic               tx_pin_o,
    output logic               rx_ser_o
);
    logic loop;
    assign loop = mcr_i[MCR_LOOP];

    // pick status levels from control bits in loopback, from pins otherwise
    always_comb begin
        if (loop) begin
            stat_o[ST_CTS] = mcr_i[MCR_RTS];
            stat_o[ST_DSR] = mcr_i[MCR_DTR];
            stat_o[ST_RI]  = mcr_i[MCR_OP1];
            stat_o[ST_DCD] = mcr_i[MCR_OP2];
        end else begin
            stat_o = ~sync_n_i;
        end
    end

    // drive modem outputs, parked inactive during loopback
    always_comb begin
        if (loop) mout_n_o = '1;
        else      mout_n_o = ~mcr_i[MODEM_W-1:0];
    end

    // serial path: echo internally in loopback, mark on the pin
    always_comb begin
        tx_pin_o = loop ? 1'b1 : tx_ser_i;
        rx_ser_o = loop ? tx_ser_i : rx_pin_i;
    end
endmodule

// File: rtl/mcs_delta.sv
// Change flags for the modem status levels, cleared by a host read.
// Assumes the ring bit reports only its trailing (1 to 0) edge.
module mcs_delta #(
    parameter int W      = 4,
    parameter int TE_BIT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_i,
    input  logic         rd_i,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] prev;
    logic [W-1:0] chg;

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            if (b == TE_BIT) begin : g_trail
                assign chg[b] = prev[b] & ~stat_i[b];
            end else begin : g_any
                assign chg[b] = prev[b] ^ stat_i[b];
            end
        end
    endgenerate

    // remember last level; during reset track it so no flag appears at release
    always_ff @(posedge clk) begin
        prev <= stat_i;
    end

    // set on change, clear on read, a same-cycle change wins over the clear
    always_ff @(posedge clk) begin
        if (!rst_n)    flag_o <= '0;
        else if (rd_i) flag_o <= chg;
        else           flag_o <= flag_o | chg;
    end
endmodule

// File: rtl/modem_ctl_stat.sv
// Modem control register, status word with change flags, loopback routing
// and clear-to-send transmit hold for one serial channel.
// Assumes host strobes are single-cycle and synchronous to clk.
module modem_ctl_stat
    import mcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mcr_wr,
    input  logic [MCR_W-1:0] mcr_wdata,
    output logic [MCR_W-1:0] mcr_q,
    input  logic             msr_rd,
    output logic [7:0]       msr_rdata,
    input  logic             cts_n_i,
    input  logic             dsr_n_i,
    input  logic             ri_n_i,
    input  logic             dcd_n_i,
    output logic             dtr_n_o,
    output logic             rts_n_o,
    output logic             op1_n_o,
    output logic             op2_n_o,
    input  logic             tx_ser_i,
    output logic             tx_pin_o,
    input  logic             rx_pin_i,
    output logic             rx_ser_o,
    input  logic             tx_idle_i,
    output logic             tx_hold_o,
    output logic             msr_irq_o
);
    logic [MODEM_W-1:0] pins_n, sync_n, stat, flags, mout_n;

    assign pins_n = {dcd_n_i, ri_n_i, dsr_n_i, cts_n_i};

    // control register write
    always_ff @(posedge clk) begin
        if (!rst_n)      mcr_q <= '0;
        else if (mcr_wr) mcr_q <= mcr_wdata;
    end

    mcs_sync #(.W(MODEM_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (pins_n),
        .q_o (sync_n)
    );

    mcs_route u_route (
        .mcr_i    (mcr_q),
        .sync_n_i (sync_n),
        .tx_ser_i (tx_ser_i),
        .rx_pin_i (rx_pin_i),
        .stat_o   (stat),
        .mout_n_o (mout_n),
        .tx_pin_o (tx_pin_o),
        .rx_ser_o (rx_ser_o)
    );

    mcs_delta #(.W(MODEM_W), .TE_BIT(ST_RI)) u_delta (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat),
        .rd_i   (msr_rd),
        .flag_o (flags)
    );

    // transmit hold follows clear-to-send only between characters
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_hold_o <= 1'b0;
        else if (tx_idle_i) tx_hold_o <= ~stat[ST_CTS];
    end

    assign dtr_n_o   = mout_n[MCR_DTR];
    assign rts_n_o   = mout_n[MCR_RTS];
    assign op1_n_o   = mout_n[MCR_OP1];
    assign op2_n_o   = mout_n[MCR_OP2];
    assign msr_rdata = {stat, flags};
    assign msr_irq_o = |flags;
endmodule

// File: rtl/modem_ctl_stat_chk.sv
// Property checker for modem_ctl_stat, attached by bind; observes ports only.
module modem_ctl_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] mcr_q,
    input logic       msr_rd,
    input logic [7:0] msr_rdata,
    input logic       dtr_n_o,
    input logic       rts_n_o,
    input logic       op1_n_o,
    input logic       op2_n_o,
    input logic       tx_ser_i,
    input logic       tx_pin_o,
    input logic       rx_ser_o,
    input logic       tx_idle_i,
    input logic       tx_hold_o,
    input logic       msr_irq_o
);
    AST_NORMAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !mcr_q[4] |-> ({op2_n_o, op1_n_o, rts_n_o, dtr_n_o} == ~mcr_q[3:0])); // R2
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !msr_rd |=> ((msr_rdata[3:0] & $past(msr_rdata[3:0])) == $past(msr_rdata[3:0]))); // R5
    AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        msr_irq_o == (msr_rdata[3:0] != 4'h0)); // R6
    AST_LOOP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_q[4] |-> (msr_rdata[7:4] == {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1]})); // R7
    AST_LOOP_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_q[4] |-> (tx_pin_o && dtr_n_o && rts_n_o && op1_n_o && op2_n_o)); // R8
    AST_LOOP_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_q[4] |-> (rx_ser_o == tx_ser_i)); // R8
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle_i |=> $stable(tx_hold_o)); // R9
endmodule

bind modem_ctl_stat modem_ctl_stat_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mcr_q     (mcr_q),
    .msr_rd    (msr_rd),
    .msr_rdata (msr_rdata),
    .dtr_n_o   (dtr_n_o),
    .rts_n_o   (rts_n_o),
    .op1_n_o   (op1_n_o),
    .op2_n_o   (op2_n_o),
    .tx_ser_i  (tx_ser_i),
    .tx_pin_o  (tx_pin_o),
    .rx_ser_o  (rx_ser_o),
    .tx_idle_i (tx_idle_i),
    .tx_hold_o (tx_hold_o),
    .msr_irq_o (msr_irq_o)
);

// File: tb/sim_modem_ctl_stat.sv
module sim_modem_ctl_stat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mcr_wr = 1'b0;
    logic [4:0] mcr_wdata = '0;
    logic [4:0] mcr_q;
    logic       msr_rd = 1'b0;
    logic [7:0] msr_rdata;
    logic       cts_n_i = 1'b0, dsr_n_i = 1'b1, ri_n_i = 1'b1, dcd_n_i = 1'b1;
    logic       dtr_n_o, rts_n_o, op1_n_o, op2_n_o;
    logic       tx_ser_i = 1'b0, tx_pin_o, rx_pin_i = 1'b1, rx_ser_o;
    logic       tx_idle_i = 1'b1, tx_hold_o, msr_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cyc = 0;

    always #10 clk = ~clk;

    modem_ctl_stat u0 (.*);

    // Vector: {mcr[4:0], in_n{dcd,ri,dsr,cts}, exp out_n{op2,op1,rts,dtr}, exp stat{dcd,ri,dsr,cts}}
    localparam logic [16:0] VEC [9] = '{
        {5'b00000, 4'b1111, 4'b1111, 4'b0000},
        {5'b00011, 4'b0000, 4'b1100, 4'b1111},
        {5'b01100, 4'b1010, 4'b0011, 4'b0101},
        {5'b00101, 4'b0101, 4'b1010, 4'b1010},
        {5'b10000, 4'b0000, 4'b1111, 4'b0000},
        {5'b10011, 4'b1111, 4'b1111, 4'b0011},
        {5'b11100, 4'b0000, 4'b1111, 4'b1100},
        {5'b10010, 4'b1010, 4'b1111, 4'b0001},
        {5'b01010, 4'b0110, 4'b0101, 4'b1001}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_in(input logic [3:0] v);
        {dcd_n_i, ri_n_i, dsr_n_i, cts_n_i} = v;
    endtask

    task automatic wr_mcr(input logic [4:0] v);
        mcr_wdata = v; mcr_wr = 1'b1;
        @(negedge clk); mcr_wr = 1'b0;
    endtask

    task automatic rd_msr();
        msr_rd = 1'b1;
        @(negedge clk); msr_rd = 1'b0;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mcr", {3'b0, mcr_q}, 8'h00);
        chk("R1 msr", msr_rdata, 8'h10);
        chk("R1 outs", {3'b0, msr_irq_o, op2_n_o, op1_n_o, rts_n_o, dtr_n_o}, 8'h0F);

        // Table: R2 R3 R7 R8
        foreach (VEC[i]) begin
            set_in(VEC[i][11:8]);
            wr_mcr(VEC[i][16:12]);
            repeat (4) @(negedge clk);
            chk("R2/R8 modem outs", {4'b0, op2_n_o, op1_n_o, rts_n_o, dtr_n_o}, {4'b0, VEC[i][7:4]});
            chk("R3/R7 status", {4'b0, msr_rdata[7:4]}, {4'b0, VEC[i][3:0]});
            chk("R8 serial", {6'b0, tx_pin_o, rx_ser_o},
                VEC[i][16] ? 8'h02 : 8'h01);
            rd_msr();
            @(negedge clk);
        end

        // R4 R6: clear-to-send change in normal mode
        wr_mcr(5'b00000);
        set_in(4'b1111);
        repeat (4) @(negedge clk);
        rd_msr();
        chk("R6 idle irq", {7'b0, msr_irq_o}, 8'h00);
        cts_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 cts flag", {4'b0, msr_rdata[3:0]}, 8'h01);
        chk("R6 irq set", {7'b0, msr_irq_o}, 8'h01);
        // R5: read shows flags, then clears
        chk("R5 read data", msr_rdata, 8'h11);
        rd_msr();
        chk("R5 cleared", {4'b0, msr_rdata[3:0]}, 8'h00);

        // R4: ring leading edge does not flag, trailing edge does
        ri_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 ring rise", {4'b0, msr_rdata[3:0]}, 8'h00);
        ri_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 ring fall", {4'b0, msr_rdata[3:0]}, 8'h04);
        rd_msr();

        // R5: change landing in the read cycle is kept
        cts_n_i = 1'b1;
        repeat (4) @(negedge clk);
        dsr_n_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rd_msr();
        chk("R5 same-cycle keep", {4'b0, msr_rdata[3:0]}, 8'h02);
        rd_msr();

        // R7: external inputs ignored in loopback
        wr_mcr(5'b10001);
        repeat (4) @(negedge clk);
        rd_msr();
        set_in(4'b0000);
        repeat (4) @(negedge clk);
        chk("R7 pins ignored", msr_rdata, 8'h20);
        set_in(4'b1111);
        repeat (4) @(negedge clk);
        chk("R7 pins ignored again", msr_rdata, 8'h20);

        // R9: hold changes only while transmitter is idle
        wr_mcr(5'b00000);
        set_in(4'b1110);
        repeat (4) @(negedge clk);
        chk("R9 hold off", {7'b0, tx_hold_o}, 8'h00);
        tx_idle_i = 1'b0;
        cts_n_i = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 hold busy", {7'b0, tx_hold_o}, 8'h00);
        tx_idle_i = 1'b1;
        @(negedge clk);
        chk("R9 hold idle", {7'b0, tx_hold_o}, 8'h01);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule